// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This block decides the outcome of a small family of branch instructions and produces, one clock after a request, the address of the next instruction to fetch, an optional write to the general register named by the instruction, and an optional trap request with its vector. The decode stage supplies the branch type and the 4-bit mask field. The condition code, the register operand, the already computed effective address and the updated instruction address (the address of the branch plus one) come from the rest of the pipeline. The fetch side reports three facts about the branch target: whether it is absent, whether it is fetch-protected, and whether fetching it produced a parity error.

There are five branch types. Two test the mask against the condition code, in opposite senses. Two count the register up or down and branch on the sign or the value of the result. One stores a return address and always branches. A trap is raised only for the location the branch actually goes to. When the branch traps, the next address is rolled back to the address of the branch itself. The register writeback then follows the rule for that branch type and that trap kind.

Top module: `branch_resolver`

## Requirements
- R1: Type code 0 (mask-any-set) is taken when the AND of the mask and the condition code is nonzero, and otherwise falls through. A zero mask therefore always falls through. No register write occurs.
- R2: Type code 1 (mask-none-set) is taken when the AND of the mask and the condition code is zero, and otherwise falls through. A zero mask therefore always branches. No register write occurs.
- R3: Type code 2 (count-up) writes the register value plus one. It is taken when that result has its sign bit set (the most significant bit, bit 0 in big-endian numbering). A zero or positive result falls through.
- R4: Type code 3 (count-down) writes the register value minus one. It is taken only when that result is positive and nonzero.
- R5: Type code 4 (call) always branches. It writes the updated instruction address zero-extended to 32 bits, with the upper 15 bits cleared.
- R6: Without a trap, the next address is the effective address when the branch is taken and the updated instruction address when it falls through. The absent, protected and parity flags have no effect on a branch that falls through.
- R7: A taken branch whose target is absent or protected raises a trap with vector 8'h40. The next address is the updated instruction address minus one.
- R8: On an 8'h40 trap, the count-up and count-down types make no register write. The call type still writes the updated instruction address.
- R9: A taken branch whose target fetch has a parity error, and whose target is neither absent nor protected, raises a trap with vector 8'h4C and the rolled-back next address. The count types make no register write; the call type writes the updated instruction address.
- R10: Results appear exactly one clock after a request cycle. In cycles without a request, the valid, write-enable and trap outputs are low. All three are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request: a branch is presented this cycle |
| op | input | 3 | Branch type code (0..4) |
| rmask | input | 4 | Mask field of the instruction |
| cc | input | 4 | Current condition code |
| reg_val | input | 32 | Contents of the named register |
| eff_addr | input | 17 | Effective (target) address |
| upd_addr | input | 17 | Updated instruction address (branch address + 1) |
| tgt_absent | input | 1 | Target location does not exist |
| tgt_protected | input | 1 | Target location is fetch-protected |
| tgt_parity_err | input | 1 | Parity error on fetch of the target |
| res_vld | output | 1 | Result valid |
| next_addr | output | 17 | Next instruction address, or the saved address on a trap |
| wr_en | output | 1 | Register write enable |
| wr_data | output | 32 | Register write data |
| trap_req | output | 1 | Trap request |
| trap_vec | output | 8 | Trap vector |

## Verification
A wrong taken/not-taken decision shows up in next_addr in the very cycle the result is valid: the address is either the effective address or the updated one, with nothing in between. An error in the counting arithmetic shows up at once in wr_data. It shows up a second time in next_addr whenever the wrong value crosses the sign or zero boundary, so the tests include the values just around those boundaries. A mixed-up trap rule shows up within one cycle in one of three places: a wrong vector, a missing rollback of next_addr, or a register write that should or should not be there. The tests cover each branch type under both trap kinds.

// File: rtl/branch_resolver.sv
module branch_resolver #(
  parameter int AW  = 17,
  parameter int DW  = 32,
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_vld,
  input  logic [OPW-1:0] op,
  input  logic [3:0]     rmask,
  input  logic [3:0]     cc,
  input  logic [DW-1:0]  reg_val,
  input  logic [AW-1:0]  eff_addr,
  input  logic [AW-1:0]  upd_addr,
  input  logic           tgt_absent,
  input  logic           tgt_protected,
  input  logic           tgt_parity_err,
  output logic           res_vld,
  output logic [AW-1:0]  next_addr,
  output logic           wr_en,
  output logic [DW-1:0]  wr_data,
  output logic           trap_req,
  output logic [7:0]     trap_vec
);
  localparam logic [OPW-1:0] OP_ANYSET  = OPW'(0);
  localparam logic [OPW-1:0] OP_NONESET = OPW'(1);
  localparam logic [OPW-1:0] OP_CNTUP   = OPW'(2);
  localparam logic [OPW-1:0] OP_CNTDN   = OPW'(3);
  localparam logic [OPW-1:0] OP_CALL    = OPW'(4);
  localparam logic [7:0]     VEC_ACCESS = 8'h40;
  localparam logic [7:0]     VEC_PARITY = 8'h4C;

  logic          hit;
  logic [DW-1:0] up_v, dn_v, link_v;
  logic          taken, is_cnt, is_call;
  logic          acc_trap, par_trap, any_trap;
  logic          we_c;
  logic [DW-1:0] wd_c;
  logic [AW-1:0] na_c;

  assign hit    = |(rmask & cc);
  assign up_v   = reg_val + DW'(1);
  assign dn_v   = reg_val - DW'(1);
  assign link_v = {{(DW-AW){1'b0}}, upd_addr};

  always_comb begin
    taken   = 1'b0;
    is_cnt  = 1'b0;
    is_call = 1'b0;
    wd_c    = '0;
    unique case (op)
      OP_ANYSET:  taken = hit;
      OP_NONESET: taken = !hit;
      OP_CNTUP: begin
        is_cnt = 1'b1;
        wd_c   = up_v;
        taken  = up_v[DW-1];
      end
      OP_CNTDN: begin
        is_cnt = 1'b1;
        wd_c   = dn_v;
        taken  = !dn_v[DW-1] && (dn_v != '0);
      end
      OP_CALL: begin
        is_call = 1'b1;
        wd_c    = link_v;
        taken   = 1'b1;
      end
      default: ;
    endcase
  end

  assign acc_trap = taken && (tgt_absent || tgt_protected);
  assign par_trap = taken && !acc_trap && tgt_parity_err;
  assign any_trap = acc_trap || par_trap;
  assign we_c     = is_call || (is_cnt && !any_trap);
  assign na_c     = any_trap ? (upd_addr - AW'(1)) : (taken ? eff_addr : upd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      wr_en     <= 1'b0;
      trap_req  <= 1'b0;
      trap_vec  <= '0;
      next_addr <= '0;
      wr_data   <= '0;
    end else begin
      res_vld  <= req_vld;
      wr_en    <= req_vld && we_c;
      trap_req <= req_vld && any_trap;
      if (req_vld) begin
        trap_vec  <= acc_trap ? VEC_ACCESS : (par_trap ? VEC_PARITY : 8'h00);
        next_addr <= na_c;
        wr_data   <= wd_c;
      end
    end
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int AW  = 17,
  parameter int DW  = 32,
  parameter int OPW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_vld,
  input logic [OPW-1:0] op,
  input logic [3:0]     rmask,
  input logic [3:0]     cc,
  input logic [AW-1:0]  upd_addr,
  input logic           res_vld,
  input logic [AW-1:0]  next_addr,
  input logic           wr_en,
  input logic [DW-1:0]  wr_data,
  input logic           trap_req,
  input logic [7:0]     trap_vec
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> (!wr_en && !trap_req)); // R10

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(req_vld)); // R10

  AST_ANYSET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op) == OPW'(0) && (($past(rmask) & $past(cc)) == 4'd0))
      |-> (!trap_req && !wr_en && next_addr == $past(upd_addr))); // R1

  AST_NONESET_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op) == OPW'(1)) |-> !wr_en); // R2

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && $past(op) == OPW'(4))
      |-> (wr_en && wr_data == {{(DW-AW){1'b0}}, $past(upd_addr)})); // R5

  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (trap_vec == 8'h40 || trap_vec == 8'h4C)); // R7

  AST_TRAP_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (next_addr == $past(upd_addr) - AW'(1))); // R7

  AST_CNT_TRAP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && ($past(op) == OPW'(2) || $past(op) == OPW'(3))) |-> !wr_en); // R8
endmodule

bind branch_resolver branch_resolver_chk #(.AW(AW), .DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .op(op), .rmask(rmask), .cc(cc),
  .upd_addr(upd_addr), .res_vld(res_vld), .next_addr(next_addr), .wr_en(wr_en),
  .wr_data(wr_data), .trap_req(trap_req), .trap_vec(trap_vec)
);

// File: tb/tb_branch_resolver.sv
`timescale 1ns/1ps
module tb_branch_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  rmask = '0, cc = '0;
  logic [31:0] reg_val = '0;
  logic [16:0] eff_addr = '0, upd_addr = '0;
  logic        tgt_absent = 1'b0, tgt_protected = 1'b0, tgt_parity_err = 1'b0;
  logic        res_vld, wr_en, trap_req;
  logic [16:0] next_addr;
  logic [31:0] wr_data;
  logic [7:0]  trap_vec;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  branch_resolver dut (.*);

  localparam logic [16:0] EA = 17'h0_4000, UA = 17'h1_2345;

  task automatic check(string tag, logic v, logic [16:0] na, logic we, logic [31:0] wd,
                       logic tr, logic [7:0] tv);
    checks++;
    if (res_vld !== v || next_addr !== na || wr_en !== we || (we && wr_data !== wd) ||
        trap_req !== tr || (tr && trap_vec !== tv)) begin
      errors++;
      $display("FAIL %s: got vld=%0b na=%h we=%0b wd=%h trap=%0b vec=%h exp vld=%0b na=%h we=%0b wd=%h trap=%0b vec=%h",
               tag, res_vld, next_addr, wr_en, wr_data, trap_req, trap_vec, v, na, we, wd, tr, tv);
    end
  endtask

  task automatic issue(logic [2:0] o, logic [3:0] m, logic [3:0] c, logic [31:0] r,
                       logic ab, logic pr, logic pe);
    @(negedge clk);
    req_vld = 1'b1; op = o; rmask = m; cc = c; reg_val = r;
    eff_addr = EA; upd_addr = UA;
    tgt_absent = ab; tgt_protected = pr; tgt_parity_err = pe;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 reset", 0, 17'h0, 0, 32'h0, 0, 8'h0);
  endtask

  task automatic t_anyset;
    issue(3'd0, 4'b0101, 4'b0100, 0, 0, 0, 0); check("R1 hit", 1, EA, 0, 0, 0, 0);
    issue(3'd0, 4'b0101, 4'b1010, 0, 0, 0, 0); check("R1 miss", 1, UA, 0, 0, 0, 0);
    issue(3'd0, 4'b0000, 4'b1111, 0, 0, 0, 0); check("R1 zero mask", 1, UA, 0, 0, 0, 0);
  endtask

  task automatic t_noneset;
    issue(3'd1, 4'b0011, 4'b1000, 0, 0, 0, 0); check("R2 none", 1, EA, 0, 0, 0, 0);
    issue(3'd1, 4'b0011, 4'b0010, 0, 0, 0, 0); check("R2 some", 1, UA, 0, 0, 0, 0);
    issue(3'd1, 4'b0000, 4'b1111, 0, 0, 0, 0); check("R2 zero mask", 1, EA, 0, 0, 0, 0);
  endtask

  task automatic t_cntup;
    issue(3'd2, 0, 0, 32'hFFFF_FFFE, 0, 0, 0); check("R3 to -1", 1, EA, 1, 32'hFFFF_FFFF, 0, 0);
    issue(3'd2, 0, 0, 32'hFFFF_FFFF, 0, 0, 0); check("R3 to 0", 1, UA, 1, 32'h0, 0, 0);
    issue(3'd2, 0, 0, 32'h7FFF_FFFF, 0, 0, 0); check("R3 wrap", 1, EA, 1, 32'h8000_0000, 0, 0);
    issue(3'd2, 0, 0, 32'h0000_0005, 0, 0, 0); check("R3 positive", 1, UA, 1, 32'h6, 0, 0);
  endtask

  task automatic t_cntdn;
    issue(3'd3, 0, 0, 32'h2, 0, 0, 0); check("R4 to 1", 1, EA, 1, 32'h1, 0, 0);
    issue(3'd3, 0, 0, 32'h1, 0, 0, 0); check("R4 to 0", 1, UA, 1, 32'h0, 0, 0);
    issue(3'd3, 0, 0, 32'h0, 0, 0, 0); check("R4 to -1", 1, UA, 1, 32'hFFFF_FFFF, 0, 0);
    issue(3'd3, 0, 0, 32'h8000_0000, 0, 0, 0); check("R4 wrap", 1, EA, 1, 32'h7FFF_FFFF, 0, 0);
  endtask

  task automatic t_call;
    issue(3'd4, 4'b1111, 4'b1111, 32'hDEAD_BEEF, 0, 0, 0);
    check("R5 link", 1, EA, 1, 32'h0001_2345, 0, 0);
  endtask

  task automatic t_untaken_bad_target;
    issue(3'd0, 4'b0001, 4'b0010, 0, 1, 1, 1); check("R6 miss ignores flags", 1, UA, 0, 0, 0, 0);
    issue(3'd3, 0, 0, 32'h1, 1, 0, 1); check("R6 count miss ignores flags", 1, UA, 1, 32'h0, 0, 0);
  endtask

  task automatic t_access_trap;
    issue(3'd1, 4'b0000, 4'b0000, 0, 0, 1, 0); check("R7 protected", 1, UA - 17'd1, 0, 0, 1, 8'h40);
    issue(3'd0, 4'b1000, 4'b1000, 0, 1, 0, 1); check("R7 absent over parity", 1, UA - 17'd1, 0, 0, 1, 8'h40);
    issue(3'd2, 0, 0, 32'hFFFF_FFF0, 0, 1, 0); check("R8 count-up no write", 1, UA - 17'd1, 0, 0, 1, 8'h40);
    issue(3'd4, 0, 0, 0, 0, 1, 0); check("R8 call writes", 1, UA - 17'd1, 1, 32'h0001_2345, 1, 8'h40);
  endtask

  task automatic t_parity_trap;
    issue(3'd3, 0, 0, 32'h10, 0, 0, 1); check("R9 count-down no write", 1, UA - 17'd1, 0, 0, 1, 8'h4C);
    issue(3'd4, 0, 0, 0, 0, 0, 1); check("R9 call writes", 1, UA - 17'd1, 1, 32'h0001_2345, 1, 8'h4C);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R10 idle", 0, next_addr, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_anyset();
    t_noneset();
    t_cntup();
    t_cntdn();
    t_call();
    t_untaken_bad_target();
    t_access_trap();
    t_parity_trap();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule